// File: doc/BRIEF.md
# Scatter-Gather DMA Status and Interrupt Register Unit

This block is the register front end of a scatter-gather DMA engine. A 32-bit register port with a byte address reaches three registers: status at offset 0x00, control at 0x10 and the next-descriptor pointer at 0x20. The descriptor sequencer reports error, end-of-packet, descriptor-done and chain-done events as one-cycle pulses. The block latches these pulses into sticky status bits. It counts completed descriptors and drives one level-sensitive interrupt line. It also supplies the sequencer with its run, halt-on-error, polling, polling-interval, ownership-clear and software-reset controls.

Each event can be enabled for the interrupt on its own, and a global enable gates all of them. A second source raises the interrupt when a programmed number of descriptors has completed. Writing control bit 31 drops the pending interrupt and restarts the descriptor count. A write of control bit 16 starts a software reset. The reset clears the status bits, the count and the pending interrupt in the write cycle, and it pulses the reset output for exactly one cycle.

A small state machine holds the interrupt line, with three states:
- `IRQ_IDLE`: no interrupt pending.
- `IRQ_PEND`: the interrupt line is high.
- `IRQ_SRST`: the one-cycle software-reset pulse.

Its transitions are:
- `IRQ_IDLE` goes to `IRQ_PEND` on a qualified trigger.
- `IRQ_PEND` goes to `IRQ_IDLE` on a clear write that has no trigger in the same cycle.
- Any state goes to `IRQ_SRST` on a reset write.
- `IRQ_SRST` goes to `IRQ_PEND` on a trigger, and otherwise to `IRQ_IDLE`.

Top module: `dma_csr_unit`

## Requirements
- R1: After reset, all three registers read zero, and `irq_o` and `sw_reset_o` are low.
- R2: The status register has four sticky bits: bit 0 error, bit 1 end of packet, bit 2 descriptor done and bit 3 chain done. Each bit is set in the cycle after its event pulse. It stays set until a status write carries a one in that bit position. A zero written to that position leaves it unchanged.
- R3: Status bit 4 shows the `busy_i` input as it is now. Status bits 31:5 read zero. Writes to bits 31:4 change nothing.
- R4: When an event pulse and a clearing write fall in the same cycle, the event wins. This holds both for the status bit and for the pending interrupt.
- R5: Control bits 15:0 except bit 16, and bits 26:17, read back as written. Bits 30:27 and bit 31 read zero. The outputs follow the stored bits:
  - `run_o` follows bit 5 and `halt_on_err_o` follows bit 6.
  - `owner_clr_sel_o` follows bit 17 and `poll_en_o` follows bit 18.
  - `poll_gap_o` follows bits 26:19.
- R6: The next-descriptor register at 0x20 holds all 32 bits and drives `next_desc_o`. Any other offset reads zero.
- R7: An interrupt trigger raises `irq_o` in the next cycle. A trigger is an event whose enable is set (bit 0 error, bit 1 end of packet, bit 2 every descriptor, bit 3 chain done) while global enable bit 4 is set. `irq_o` then stays high until it is cleared. The enables are taken from the control value held before any write in the same cycle.
- R8: With control bit 4 clear, no event and no descriptor count raises `irq_o`.
- R9: Each descriptor-done pulse advances the descriptor count. The pulse that brings the count to the value in control bits 15:8 restarts the count at zero. If bits 7 and 4 are set, that pulse also raises `irq_o`. A programmed value of zero never raises this interrupt.
- R10: A control write with bit 31 set drops `irq_o` in the next cycle and restarts the descriptor count. This applies unless a trigger falls in the same cycle.
- R11: A control write with bit 16 set clears the status bits, the count and the pending interrupt at that edge. During the following cycle only, `sw_reset_o` is high and control bit 16 reads one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_err | input | 1 | Error event pulse |
| ev_eop | input | 1 | End-of-packet event pulse |
| ev_desc | input | 1 | Descriptor-done event pulse |
| ev_chain | input | 1 | Chain-done event pulse |
| busy_i | input | 1 | Sequencer busy level |
| irq_o | output | 1 | Level interrupt |
| run_o | output | 1 | Start descriptor processing |
| halt_on_err_o | output | 1 | Stop on DMA error |
| poll_en_o | output | 1 | Descriptor polling enable |
| poll_gap_o | output | INTV_W | Clocks between polls |
| owner_clr_sel_o | output | 1 | Ownership-clear select |
| sw_reset_o | output | 1 | One-cycle software reset pulse |
| next_desc_o | output | 32 | Next-descriptor pointer |

## Verification
The interrupt path is tried with three kinds of stimulus. Single enabled events with the global enable clear and then set tell the per-event qualification apart from the global gate. Runs of descriptor-done pulses against limits of three and zero tell a count that restarts from one that wraps or is disabled. Event pulses placed in the same cycle as status-clear, interrupt-clear and reset writes expose which side wins at each collision. A behavioural model of every register and output is compared on each clock, so any divergence is caught in the cycle it appears.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int REG_W      = 32;
    localparam int EV_N       = 4;

    localparam int OFS_STATUS = 'h00;
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_NEXT   = 'h20;

    localparam int ST_BUSY    = 4;

    localparam int CB_IE_ERR  = 0;
    localparam int CB_GIE     = 4;
    localparam int CB_RUN     = 5;
    localparam int CB_HALT    = 6;
    localparam int CB_IE_MAX  = 7;
    localparam int CB_MAX_LO  = 8;
    localparam int CB_SRST    = 16;
    localparam int CB_OWNCLR  = 17;
    localparam int CB_POLL    = 18;
    localparam int CB_GAP_LO  = 19;
    localparam int CB_CLRINT  = 31;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_PEND = 2'd1,
        IRQ_SRST = 2'd2
    } irq_state_e;

endpackage

// File: rtl/dma_csr_events.sv
module dma_csr_events
    import dma_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_clr,
    input  logic            clr_wr,
    input  logic [EV_N-1:0] clr_mask,
    input  logic [EV_N-1:0] ev,
    output logic [EV_N-1:0] sticky
);

    for (genvar i = 0; i < EV_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky[i] <= 1'b0;
            end else if (sw_clr) begin
                sticky[i] <= 1'b0;
            end else begin
                sticky[i] <= (sticky[i] & ~(clr_wr & clr_mask[i])) | ev[i];
            end
        end

        // R2 / R4: a pulse always lands, even beside a clearing write
        a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !sw_clr) |=> sticky[i]);

        // R2: a set bit survives any cycle without a matching one-write
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky[i] && !sw_clr && !(clr_wr && clr_mask[i])) |=> sticky[i]);
    end

endmodule

// File: rtl/dma_csr_desc_cnt.sv
module dma_csr_desc_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_clr,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] inc;

    always_comb begin
        base = clr ? '0 : cnt_q;
        inc  = base + 1'b1;
        hit  = step && (limit != '0) && (inc == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= hit ? '0 : inc;
        end else begin
            cnt_q <= base;
        end
    end

    // R9: the count restarts after reaching the programmed value
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0));

    // R10: a clear write with no pulse leaves the count at zero
    a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !step) |=> (cnt_q == '0));

endmodule

// File: rtl/dma_csr_irq_fsm.sv
module dma_csr_irq_fsm
    import dma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    input  logic clr_req,
    input  logic fire,
    output logic irq_o,
    output logic sw_reset_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (srst_req) begin
            state_d = IRQ_SRST;
        end else begin
            unique case (state_q)
                IRQ_IDLE: state_d = fire ? IRQ_PEND : IRQ_IDLE;
                IRQ_PEND: state_d = (clr_req && !fire) ? IRQ_IDLE : IRQ_PEND;
                IRQ_SRST: state_d = fire ? IRQ_PEND : IRQ_IDLE;
                default:  state_d = IRQ_IDLE;
            endcase
        end
    end

    always_comb begin
        irq_o      = (state_q == IRQ_PEND);
        sw_reset_o = (state_q == IRQ_SRST);
    end

    // R7: a qualified trigger raises the line next cycle
    a_r7_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !srst_req) |=> irq_o);

    // R10: a clear without a trigger drops the line
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !fire && !srst_req) |=> !irq_o);

    // R11: a reset write gives a pulse with the line low
    a_r11_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (sw_reset_o && !irq_o));

    // R11: the pulse never lasts two cycles without a fresh request
    a_r11_srst_single: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset_o && !srst_req) |=> !sw_reset_o);

endmodule

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8,
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_err,
    input  logic              ev_eop,
    input  logic              ev_desc,
    input  logic              ev_chain,
    input  logic              busy_i,
    output logic              irq_o,
    output logic              run_o,
    output logic              halt_on_err_o,
    output logic              poll_en_o,
    output logic [INTV_W-1:0] poll_gap_o,
    output logic              owner_clr_sel_o,
    output logic              sw_reset_o,
    output logic [REG_W-1:0]  next_desc_o
);

    localparam int         CTRL_TOP  = CB_GAP_LO + INTV_W;
    localparam logic [REG_W-1:0] CTRL_KEEP =
        REG_W'((64'd1 << CTRL_TOP) - 64'd1) & ~(REG_W'(1) << CB_SRST);
    localparam int         ST_PAD    = REG_W - EV_N - 1;

    logic              sel_st, sel_ctrl, sel_next;
    logic              wr_st, wr_ctrl, wr_next;
    logic              srst_req, clr_req;
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  next_q;
    logic [EV_N-1:0]   ev_vec;
    logic [EV_N-1:0]   sticky;
    logic              max_hit;
    logic              fire;

    always_comb begin
        sel_st   = (reg_addr == ADDR_W'(OFS_STATUS));
        sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
        sel_next = (reg_addr == ADDR_W'(OFS_NEXT));
        wr_st    = reg_wr && sel_st;
        wr_ctrl  = reg_wr && sel_ctrl;
        wr_next  = reg_wr && sel_next;
        srst_req = wr_ctrl && reg_wdata[CB_SRST];
        clr_req  = wr_ctrl && reg_wdata[CB_CLRINT];
        ev_vec   = {ev_chain, ev_desc, ev_eop, ev_err};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata & CTRL_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (wr_next) begin
            next_q <= reg_wdata;
        end
    end

    dma_csr_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_clr   (srst_req),
        .clr_wr   (wr_st),
        .clr_mask (reg_wdata[EV_N-1:0]),
        .ev       (ev_vec),
        .sticky   (sticky)
    );

    dma_csr_desc_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_clr (srst_req),
        .clr    (clr_req),
        .step   (ev_desc),
        .limit  (ctrl_q[CB_MAX_LO +: CNT_W]),
        .hit    (max_hit)
    );

    always_comb begin
        fire = ctrl_q[CB_GIE] &&
               ((|(ev_vec & ctrl_q[CB_IE_ERR +: EV_N])) ||
                (max_hit && ctrl_q[CB_IE_MAX]));
    end

    dma_csr_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_req   (srst_req),
        .clr_req    (clr_req),
        .fire       (fire),
        .irq_o      (irq_o),
        .sw_reset_o (sw_reset_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_st) begin
            reg_rdata = {{ST_PAD{1'b0}}, busy_i, sticky};
        end else if (sel_ctrl) begin
            reg_rdata = ctrl_q;
            reg_rdata[CB_SRST] = sw_reset_o;
        end else if (sel_next) begin
            reg_rdata = next_q;
        end
    end

    always_comb begin
        run_o           = ctrl_q[CB_RUN];
        halt_on_err_o   = ctrl_q[CB_HALT];
        poll_en_o       = ctrl_q[CB_POLL];
        poll_gap_o      = ctrl_q[CB_GAP_LO +: INTV_W];
        owner_clr_sel_o = ctrl_q[CB_OWNCLR];
        next_desc_o     = next_q;
    end

    // R8: the line only rises after a cycle with the global enable set
    a_r8_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ctrl_q[CB_GIE]));

    // R11: a reset pulse always follows a reset write
    a_r11_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset_o |-> $past(srst_req));

    // R5: reserved and self-clearing bits are never stored
    a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0);

endmodule

// File: tb/dma_csr_unit_test.sv
`timescale 1ns/1ps
module dma_csr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_err = 1'b0, ev_eop = 1'b0, ev_desc = 1'b0, ev_chain = 1'b0;
    logic        busy_i = 1'b0;
    logic        irq_o, run_o, halt_on_err_o, poll_en_o, owner_clr_sel_o, sw_reset_o;
    logic [7:0]  poll_gap_o;
    logic [31:0] next_desc_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_csr_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_err(ev_err), .ev_eop(ev_eop), .ev_desc(ev_desc), .ev_chain(ev_chain),
        .busy_i(busy_i), .irq_o(irq_o), .run_o(run_o), .halt_on_err_o(halt_on_err_o),
        .poll_en_o(poll_en_o), .poll_gap_o(poll_gap_o),
        .owner_clr_sel_o(owner_clr_sel_o), .sw_reset_o(sw_reset_o),
        .next_desc_o(next_desc_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    bit [3:0]  m_st;
    bit [31:0] m_ctrl;
    bit [31:0] m_next;
    bit        m_irq;
    bit        m_srst;
    int        m_cnt;
    bit        m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ctrl = 0; m_next = 0; m_irq = 0; m_srst = 0; m_cnt = 0;
            m_live = 0;
        end else begin
            automatic bit wc = reg_wr && reg_addr == 6'h10;
            automatic bit ws = reg_wr && reg_addr == 6'h00;
            automatic bit wn = reg_wr && reg_addr == 6'h20;
            automatic bit clr = wc && reg_wdata[31];
            automatic bit rst_req = wc && reg_wdata[16];
            automatic int lim = m_ctrl[15:8];
            automatic int base = clr ? 0 : m_cnt;
            automatic bit hit = ev_desc && lim != 0 && ((base + 1) % 256) == lim;
            automatic bit [3:0] ev = {ev_chain, ev_desc, ev_eop, ev_err};
            automatic bit trig = m_ctrl[4] && ((ev & m_ctrl[3:0]) != 0 || (hit && m_ctrl[7]));
            if (rst_req) begin
                m_st = 0; m_cnt = 0; m_irq = 0; m_srst = 1;
            end else begin
                m_st = (ws ? (m_st & ~reg_wdata[3:0]) : m_st) | ev;
                m_cnt = ev_desc ? (hit ? 0 : (base + 1) % 256) : base;
                m_irq = trig ? 1'b1 : (clr ? 1'b0 : m_irq);
                m_srst = 0;
            end
            if (wc) m_ctrl = reg_wdata & 32'h07FE_FFFF;
            if (wn) m_next = reg_wdata;
            m_live = 1;
        end
    end

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00:   return {27'b0, busy_i, m_st};
            6'h10:   return m_ctrl | (32'(m_srst) << 16);
            6'h20:   return m_next;
            default: return 32'h0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk("R7 model irq", {31'b0, irq_o}, {31'b0, m_irq});
            chk("R11 model sw_reset", {31'b0, sw_reset_o}, {31'b0, m_srst});
            chk("R5 model outputs", {27'b0, run_o, halt_on_err_o, poll_en_o, owner_clr_sel_o, 1'b0},
                {27'b0, m_ctrl[5], m_ctrl[6], m_ctrl[18], m_ctrl[17], 1'b0});
            chk("R5 model poll gap", {24'b0, poll_gap_o}, {24'b0, m_ctrl[26:19]});
            chk("R6 model next", next_desc_o, m_next);
            chk("R2 model readback", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic wr_ev(input logic [5:0] a, input logic [31:0] d, input logic [3:0] m);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        {ev_chain, ev_desc, ev_eop, ev_err} = m;
        @(posedge clk); #1;
        reg_wr = 0;
        {ev_chain, ev_desc, ev_eop, ev_err} = 4'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(posedge clk); #1;
        {ev_chain, ev_desc, ev_eop, ev_err} = m;
        @(posedge clk); #1;
        {ev_chain, ev_desc, ev_eop, ev_err} = 4'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(6'h00, v); chk("R1 status", v, 32'h0);
        rd(6'h10, v); chk("R1 control", v, 32'h0);
        rd(6'h20, v); chk("R1 next", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 sw_reset", {31'b0, sw_reset_o}, 32'h0);

        // R6 next pointer and unmapped offsets
        wr(6'h20, 32'hDEAD_BEEF);
        rd(6'h20, v); chk("R6 next readback", v, 32'hDEAD_BEEF);
        chk("R6 next output", next_desc_o, 32'hDEAD_BEEF);
        rd(6'h30, v); chk("R6 unmapped 0x30", v, 32'h0);
        rd(6'h04, v); chk("R6 unmapped 0x04", v, 32'h0);

        // R5 control readback and outputs
        wr(6'h10, 32'hFFFE_FF60);
        rd(6'h10, v); chk("R5 control readback", v, 32'h07FE_FF60);
        chk("R5 run", {31'b0, run_o}, 32'h1);
        chk("R5 halt", {31'b0, halt_on_err_o}, 32'h1);
        chk("R5 poll", {31'b0, poll_en_o}, 32'h1);
        chk("R5 own", {31'b0, owner_clr_sel_o}, 32'h1);
        chk("R5 gap", {24'b0, poll_gap_o}, 32'hFF);
        wr(6'h10, 32'h0);
        chk("R5 run off", {31'b0, run_o}, 32'h0);

        // R3 busy mirror and read-only upper bits
        busy_i = 1;
        rd(6'h00, v); chk("R3 busy high", v, 32'h10);
        wr(6'h00, 32'hFFFF_FFF0);
        rd(6'h00, v); chk("R3 write ignored", v, 32'h10);
        busy_i = 0;
        rd(6'h00, v); chk("R3 busy low", v, 32'h0);

        // R2 sticky bits and write-one clear
        pulse(4'b0001);
        rd(6'h00, v); chk("R2 error set", v, 32'h1);
        wr(6'h00, 32'h0);
        rd(6'h00, v); chk("R2 zero write keeps", v, 32'h1);
        pulse(4'b1000);
        rd(6'h00, v); chk("R2 chain set", v, 32'h9);
        wr(6'h00, 32'h1);
        rd(6'h00, v); chk("R2 clear error only", v, 32'h8);
        wr(6'h00, 32'h8);
        rd(6'h00, v); chk("R2 clear chain", v, 32'h0);

        // R4 event beside status clear
        pulse(4'b0010);
        wr_ev(6'h00, 32'h2, 4'b0010);
        rd(6'h00, v); chk("R4 status event wins", v, 32'h2);
        wr(6'h00, 32'h2);
        rd(6'h00, v); chk("R4 later clear", v, 32'h0);

        // R8 no interrupt without global enable
        wr(6'h10, 32'h0000_000F);
        pulse(4'b1111);
        chk("R8 gated", {31'b0, irq_o}, 32'h0);
        wr(6'h00, 32'hF);

        // R7 qualified event raises and holds
        wr(6'h10, 32'h0000_001F);
        pulse(4'b0010);
        chk("R7 raised", {31'b0, irq_o}, 32'h1);
        repeat (3) @(posedge clk); #1;
        chk("R7 held", {31'b0, irq_o}, 32'h1);

        // R10 clear bit
        wr(6'h10, 32'h8000_001F);
        chk("R10 cleared", {31'b0, irq_o}, 32'h0);
        rd(6'h10, v); chk("R10 bit31 reads zero", v, 32'h1F);

        // R4 trigger beside interrupt clear
        wr_ev(6'h10, 32'h8000_001F, 4'b0001);
        chk("R4 irq event wins", {31'b0, irq_o}, 32'h1);
        wr(6'h10, 32'h8000_001F);
        chk("R4 irq then cleared", {31'b0, irq_o}, 32'h0);

        // R9 descriptor count limit of three
        wr(6'h00, 32'hF);
        wr(6'h10, 32'h8000_0390);
        pulse(4'b0100); pulse(4'b0100);
        chk("R9 below limit", {31'b0, irq_o}, 32'h0);
        pulse(4'b0100);
        chk("R9 limit reached", {31'b0, irq_o}, 32'h1);
        wr(6'h10, 32'h8000_0390);
        pulse(4'b0100); pulse(4'b0100);
        chk("R9 restarted", {31'b0, irq_o}, 32'h0);
        pulse(4'b0100);
        chk("R9 second round", {31'b0, irq_o}, 32'h1);

        // R10 clear also restarts the count
        wr(6'h10, 32'h8000_0390);
        pulse(4'b0100); pulse(4'b0100);
        wr(6'h10, 32'h8000_0390);
        pulse(4'b0100); pulse(4'b0100);
        chk("R10 count restarted", {31'b0, irq_o}, 32'h0);
        pulse(4'b0100);
        chk("R10 limit after restart", {31'b0, irq_o}, 32'h1);

        // R9 zero limit never fires
        wr(6'h10, 32'h8000_0090);
        for (int i = 0; i < 5; i++) pulse(4'b0100);
        chk("R9 zero limit", {31'b0, irq_o}, 32'h0);

        // R11 software reset
        wr(6'h10, 32'h0000_0011);
        pulse(4'b1001);
        chk("R11 irq before", {31'b0, irq_o}, 32'h1);
        wr(6'h10, 32'h0001_0011);
        chk("R11 pulse high", {31'b0, sw_reset_o}, 32'h1);
        chk("R11 irq dropped", {31'b0, irq_o}, 32'h0);
        rd(6'h10, v); chk("R11 bit16 reads one", v, 32'h0001_0011);
        rd(6'h00, v); chk("R11 status cleared", v, 32'h0);
        @(posedge clk); #1;
        chk("R11 pulse ended", {31'b0, sw_reset_o}, 32'h0);
        rd(6'h10, v); chk("R11 bit16 self-cleared", v, 32'h11);

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule